// File: doc/BRIEF.md
# PCI Initiator Transaction Sequencer

This block runs the initiator side of one conventional 32-bit PCI bus transaction at a time. A local client presents a start address, a four-bit bus command and a word count. The block then drives the address phase and the data phases that follow. It generates the active-low frame and initiator-ready lines, and it switches the drive enables for the multiplexed address/data lines and the command/byte-enable lines. It samples the target's ready, select and stop lines. One word moves on every clock edge at which both ready lines are low. The final word is flagged by releasing frame while initiator-ready stays low.

Write data is supplied by the local client, indexed by the running word count. A local "data not ready" input makes the block delay initiator-ready, and so insert wait states, but only until initiator-ready is asserted for the current data phase. After that, initiator-ready and frame are frozen until the phase completes. A target that never claims the cycle ends the transaction with a master-abort flag. A target that signals stop ends it early, and the count of words moved is reported. Every transaction ends with one turnaround clock before the sequencer is idle again.

Top module: `pci_init_seq`

## Requirements
- R1: While idle, `busy` is low, `frame_n` and `irdy_n` are high and both drive enables are low. A request is accepted only when idle with `req_len` non-zero. A request of length zero, or one raised while busy, starts no transaction.
- R2: The first clock with `frame_n` low is the address phase. In that clock `ad_o` carries the request address, `cbe_o` carries the command, both enables are high and `irdy_n` is high. Data phases begin on the next clock.
- R3: A word is transferred at each clock edge where `irdy_n` and `trdy_n` are both low during a data phase. `word_strobe` is high in that clock and `words_done` increments after it. For commands with bit 0 set (writes), `ad_oe` is high in data phases and `ad_o` carries `wr_data`.
- R4: Once `irdy_n` is low, neither `irdy_n` nor `frame_n` changes until a transfer or a stop completes the phase, or a master-abort starts.
- R5: For a request of N words, `frame_n` is high during the N-th transfer and low during earlier transfers. `irdy_n` is low whenever `frame_n` rises.
- R6: While `irdy_n` is high in a data phase (or in the address phase), a high `data_not_ready` keeps `irdy_n` high on the next clock. Once it is low, `irdy_n` is asserted.
- R7: If `devsel_n` is not sampled low at any of the first DEVSEL_TMO data-phase clock edges (default 5), the block drives one clock with `frame_n` high and `irdy_n` low, sets `master_abort` and counts no words.
- R8: When `stop_n` is sampled low in a data phase, `frame_n` goes high. The current phase completes (a word is counted only if `trdy_n` was low with `irdy_n`), `stopped` is set and `words_done` reports the words moved.
- R9: Each transaction ends with one clock where `done` is high, `frame_n` and `irdy_n` are high and both enables are low. `busy` is low on the following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start request |
| req_addr | input | 32 | Start byte address |
| req_cmd | input | 4 | Bus command; bit 0 set means write |
| req_len | input | LEN_W | Number of data words |
| data_not_ready | input | 1 | Local data not yet available; delays IRDY |
| wr_data | input | 32 | Write word for index `words_done` |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | Turnaround clock ending a transaction |
| word_strobe | output | 1 | A word transfers at the end of this clock |
| words_done | output | LEN_W | Words transferred so far |
| master_abort | output | 1 | Last transaction was not claimed |
| stopped | output | 1 | Last transaction ended by target stop |
| frame_n | output | 1 | FRAME# to bus |
| irdy_n | output | 1 | IRDY# to bus |
| ad_o | output | 32 | Address/data drive value |
| ad_oe | output | 1 | Address/data drive enable |
| cbe_o | output | 4 | Command / byte-enable drive value (all bytes enabled in data phases) |
| cbe_oe | output | 1 | Command/byte-enable drive enable |
| trdy_n | input | 1 | TRDY# from target |
| devsel_n | input | 1 | DEVSEL# from target |
| stop_n | input | 1 | STOP# from target |

## Verification
The hardest case to reach from the ports is a clock where initiator-ready is already low but the target is not ready. The freeze rule applies there, and it has to be separated from the legitimate changes made by stop and master-abort. The bench uses a target model driven from a vector table, with a claim delay, a ready delay, a stop point and a rotating data-not-ready mask. Waits then land inside held phases, on the final word, and exactly on both sides of the claim deadline (claim at the fifth data clock, and at the sixth). Monitors at every edge compare the frame and ready lines against the rules above.

// File: rtl/pci_init_seq.sv
module pci_init_seq #(
  parameter int LEN_W      = 8,
  parameter int DEVSEL_TMO = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [31:0]      req_addr,
  input  logic [3:0]       req_cmd,
  input  logic [LEN_W-1:0] req_len,
  input  logic             data_not_ready,
  input  logic [31:0]      wr_data,
  output logic             busy,
  output logic             done,
  output logic             word_strobe,
  output logic [LEN_W-1:0] words_done,
  output logic             master_abort,
  output logic             stopped,
  output logic             frame_n,
  output logic             irdy_n,
  output logic [31:0]      ad_o,
  output logic             ad_oe,
  output logic [3:0]       cbe_o,
  output logic             cbe_oe,
  input  logic             trdy_n,
  input  logic             devsel_n,
  input  logic             stop_n
);

  localparam int TW = $clog2(DEVSEL_TMO + 1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_DATA, S_FIN, S_TURN} st_t;

  st_t              st;
  logic [LEN_W-1:0] remain;
  logic [31:0]      addr_q;
  logic [3:0]       cmd_q;
  logic [TW-1:0]    tmr;
  logic             seen;

  wire in_data = (st == S_DATA);
  wire last1   = (remain == LEN_W'(1));
  wire last2   = (remain == LEN_W'(2));
  wire tmo     = in_data && !seen && devsel_n && (tmr == TW'(DEVSEL_TMO - 1));
  wire xfer    = !irdy_n && !trdy_n && (in_data || (st == S_FIN && !master_abort));

  assign busy        = (st != S_IDLE);
  assign done        = (st == S_TURN);
  assign word_strobe = xfer;
  assign ad_o        = (st == S_ADDR) ? addr_q : wr_data;
  assign cbe_o       = (st == S_ADDR) ? cmd_q : 4'h0;
  assign cbe_oe      = (st == S_ADDR) || in_data || (st == S_FIN);
  assign ad_oe       = (st == S_ADDR) || ((in_data || st == S_FIN) && cmd_q[0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      frame_n      <= 1'b1;
      irdy_n       <= 1'b1;
      remain       <= '0;
      words_done   <= '0;
      master_abort <= 1'b0;
      stopped      <= 1'b0;
      addr_q       <= '0;
      cmd_q        <= '0;
      tmr          <= '0;
      seen         <= 1'b0;
    end else begin
      if (xfer) begin
        words_done <= words_done + LEN_W'(1);
        remain     <= remain - LEN_W'(1);
      end
      case (st)
        S_IDLE: if (req_valid && req_len != '0) begin
          st           <= S_ADDR;
          frame_n      <= 1'b0;
          addr_q       <= req_addr;
          cmd_q        <= req_cmd;
          remain       <= req_len;
          words_done   <= '0;
          master_abort <= 1'b0;
          stopped      <= 1'b0;
          tmr          <= '0;
          seen         <= 1'b0;
        end
        S_ADDR: begin
          st      <= S_DATA;
          irdy_n  <= data_not_ready;
          frame_n <= !data_not_ready && last1;
        end
        S_DATA: begin
          if (!devsel_n) seen <= 1'b1;
          else if (!seen) tmr <= tmr + TW'(1);
          if (tmo) begin
            st           <= S_FIN;
            frame_n      <= 1'b1;
            irdy_n       <= 1'b0;
            master_abort <= 1'b1;
          end else if (!stop_n) begin
            stopped <= 1'b1;
            if (!irdy_n && frame_n) begin
              st     <= S_TURN;
              irdy_n <= 1'b1;
            end else begin
              st      <= S_FIN;
              frame_n <= 1'b1;
              irdy_n  <= 1'b0;
            end
          end else if (xfer) begin
            if (frame_n) begin
              st     <= S_TURN;
              irdy_n <= 1'b1;
            end else begin
              irdy_n  <= data_not_ready;
              frame_n <= !data_not_ready && last2;
            end
          end else if (irdy_n && !data_not_ready) begin
            irdy_n  <= 1'b0;
            frame_n <= last1;
          end
        end
        S_FIN: begin
          st     <= S_TURN;
          irdy_n <= 1'b1;
        end
        S_TURN: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pci_init_seq_chk.sv
module pci_init_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic word_strobe,
  input logic master_abort,
  input logic stopped,
  input logic frame_n,
  input logic irdy_n,
  input logic ad_oe,
  input logic cbe_oe,
  input logic data_not_ready,
  input logic trdy_n,
  input logic stop_n
);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (frame_n && irdy_n && !ad_oe && !cbe_oe));

  assert_addr_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frame_n) |-> (irdy_n && ad_oe && cbe_oe));

  assert_strobe_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    word_strobe |-> (!irdy_n && !trdy_n));

  assert_irdy_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !irdy_n && trdy_n && stop_n && !stopped && !master_abort)
      |=> (($stable(irdy_n) && $stable(frame_n)) || $rose(master_abort)));

  assert_frame_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $rose(frame_n)) |-> !irdy_n);

  assert_wait_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && irdy_n && !frame_n && data_not_ready && stop_n && !master_abort)
      |=> (irdy_n || $rose(master_abort)));

  assert_abort_phase_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(master_abort) |-> (frame_n && !irdy_n));

  assert_stop_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stopped) |-> frame_n);

  assert_turn_lines_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (irdy_n && frame_n && !ad_oe && !cbe_oe));

  assert_turn_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

endmodule

bind pci_init_seq pci_init_seq_chk u_chk (.*);

// File: tb/test_pci_init_seq.sv
module test_pci_init_seq;
  localparam int LEN_W = 8;
  localparam logic [31:0] WBASE = 32'hA000_0000;
  localparam int NV = 9;
  // len, cmd, claim delay, ready delay, stop at, dnr mask, exp words, exp abort, exp stopped
  localparam int VT [0:NV-1][0:8] = '{
    '{1,  7, 1,   0, 0, 0,   1,  0, 0},
    '{4,  6, 2,   1, 0, 0,   4,  0, 0},
    '{5,  7, 1,   0, 0, 85,  5,  0, 0},
    '{6,  6, 1,   0, 3, 0,   3,  0, 1},
    '{3,  7, 255, 0, 0, 0,   0,  1, 0},
    '{2,  7, 4,   0, 2, 0,   2,  0, 1},
    '{1,  7, 5,   0, 0, 0,   1,  0, 0},
    '{2,  7, 6,   0, 0, 0,   0,  1, 0},
    '{10, 7, 3,   2, 0, 51,  10, 0, 0}
  };

  logic clk = 0, rst_n = 0;
  logic req_valid = 0;
  logic [31:0] req_addr = '0;
  logic [3:0] req_cmd = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic data_not_ready = 0;
  logic [31:0] wr_data;
  logic busy, done, word_strobe, master_abort, stopped, frame_n, irdy_n, ad_oe, cbe_oe;
  logic [LEN_W-1:0] words_done;
  logic [31:0] ad_o;
  logic [3:0] cbe_o;
  logic trdy_n = 1, devsel_n = 1, stop_n = 1;

  int tests = 0, fails = 0;
  int v_len = 0, v_cmd = 0, v_dly = 255, v_tw = 0, v_stop = 0, v_dnr = 0;
  int tb_x = 0, tcyc = 0, gcyc = 0;
  bit in_bus = 0, fz_pend = 0, fz_i = 0, fz_f = 0, w_pend = 0;
  int viol_r2 = 0, viol_r3 = 0, viol_r4 = 0, viol_r5 = 0, viol_r6 = 0;

  assign wr_data = WBASE + 32'(words_done);

  always #2 clk = ~clk;

  pci_init_seq #(.LEN_W(LEN_W), .DEVSEL_TMO(5)) i_pci_init_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_cmd(req_cmd), .req_len(req_len), .data_not_ready(data_not_ready),
    .wr_data(wr_data), .busy(busy), .done(done), .word_strobe(word_strobe),
    .words_done(words_done), .master_abort(master_abort), .stopped(stopped),
    .frame_n(frame_n), .irdy_n(irdy_n), .ad_o(ad_o), .ad_oe(ad_oe),
    .cbe_o(cbe_o), .cbe_oe(cbe_oe), .trdy_n(trdy_n), .devsel_n(devsel_n),
    .stop_n(stop_n));

  // edge monitor: transfers, data (R3), final-word framing (R5), freeze and wait tracking
  always @(posedge clk) begin
    if (frame_n && irdy_n) tb_x <= 0;
    else if (!irdy_n && !trdy_n && busy && !master_abort) begin
      if (!word_strobe) viol_r3 <= viol_r3 + 1;
      if (v_cmd[0] && (!ad_oe || ad_o != WBASE + 32'(tb_x))) viol_r3 <= viol_r3 + 1;
      if (stop_n && (tb_x + 1 == v_len) && !frame_n) viol_r5 <= viol_r5 + 1;
      if (stop_n && (tb_x + 1 < v_len) && frame_n) viol_r5 <= viol_r5 + 1;
      tb_x <= tb_x + 1;
    end
    fz_pend <= busy && !irdy_n && trdy_n && stop_n && !devsel_n && !stopped && !master_abort;
    fz_i <= irdy_n;
    fz_f <= frame_n;
    w_pend <= busy && irdy_n && !frame_n && data_not_ready && stop_n;
  end

  // target model and local readiness, updated away from the active edge
  always @(negedge clk) begin
    gcyc <= gcyc + 1;
    data_not_ready <= v_dnr[gcyc % 8];
    if (fz_pend && (irdy_n != fz_i || frame_n != fz_f)) viol_r4 <= viol_r4 + 1;
    if (w_pend && !irdy_n) viol_r6 <= viol_r6 + 1;
    if (frame_n && irdy_n) begin
      in_bus <= 0;
      devsel_n <= 1; trdy_n <= 1; stop_n <= 1;
    end else begin
      int c;
      c = in_bus ? tcyc + 1 : 0;
      if (!in_bus && (ad_o != req_addr || cbe_o != req_cmd || !ad_oe || !cbe_oe || !irdy_n))
        viol_r2 <= viol_r2 + 1;
      tcyc <= c;
      in_bus <= 1;
      devsel_n <= !(c >= v_dly);
      trdy_n <= !(c >= v_dly + v_tw && !(v_stop != 0 && tb_x >= v_stop));
      stop_n <= !(v_stop != 0 && c >= v_dly + v_tw && tb_x >= v_stop - 1);
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run_vec(input int i);
    int b2, b3, b4, b5, b6, n;
    b2 = viol_r2; b3 = viol_r3; b4 = viol_r4; b5 = viol_r5; b6 = viol_r6;
    v_len = VT[i][0]; v_cmd = VT[i][1]; v_dly = VT[i][2];
    v_tw = VT[i][3]; v_stop = VT[i][4]; v_dnr = VT[i][5];
    @(negedge clk);
    req_addr = 32'h1000_0000 + 32'(i * 64);
    req_cmd = 4'(v_cmd);
    req_len = LEN_W'(v_len);
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    n = 0;
    while (!done && n < 500) begin @(negedge clk); n++; end
    chk(done == 1, "R9 done reached", int'(done), 1);
    chk(int'(words_done) == VT[i][6], "R3/R8 words_done", int'(words_done), VT[i][6]);
    chk(tb_x == VT[i][6], "R3 bus transfers", tb_x, VT[i][6]);
    chk(master_abort == VT[i][7][0], "R7 master_abort", int'(master_abort), VT[i][7]);
    chk(stopped == VT[i][8][0], "R8 stopped", int'(stopped), VT[i][8]);
    chk(irdy_n && frame_n && !ad_oe && !cbe_oe, "R9 turnaround lines",
        int'({irdy_n, frame_n, ad_oe, cbe_oe}), 12);
    @(negedge clk);
    chk(!busy, "R9 idle after turnaround", int'(busy), 0);
    v_dnr = 0;
    chk(viol_r2 == b2, "R2 address phase", viol_r2 - b2, 0);
    chk(viol_r3 == b3, "R3 data words", viol_r3 - b3, 0);
    chk(viol_r4 == b4, "R4 frozen phase", viol_r4 - b4, 0);
    chk(viol_r5 == b5, "R5 final framing", viol_r5 - b5, 0);
    chk(viol_r6 == b6, "R6 wait hold", viol_r6 - b6, 0);
  endtask

  initial begin
    #(4 * 150000);
    tests++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && frame_n && irdy_n && !ad_oe && !cbe_oe && !done, "R1 reset state",
        int'({busy, frame_n, irdy_n, ad_oe, cbe_oe}), 12);
    chk(!master_abort && !stopped && words_done == 0, "R1 reset flags",
        int'({master_abort, stopped}), 0);

    for (int i = 0; i < NV; i++) run_vec(i);

    // R1: zero length ignored
    req_len = '0; req_cmd = 4'h7; req_valid = 1;
    @(negedge clk); req_valid = 0;
    repeat (2) @(negedge clk);
    chk(!busy && frame_n, "R1 zero length ignored", int'(busy), 0);

    // R1: request while busy ignored
    v_len = 3; v_cmd = 7; v_dly = 1; v_tw = 2; v_stop = 0;
    req_addr = 32'h2000_0000; req_cmd = 4'h7; req_len = 8'd3; req_valid = 1;
    @(negedge clk); req_valid = 0;
    repeat (2) @(negedge clk);
    req_len = 8'd1; req_valid = 1;
    @(negedge clk); req_valid = 0;
    while (!done) @(negedge clk);
    chk(words_done == 3, "R1 busy request ignored words", int'(words_done), 3);
    repeat (3) @(negedge clk);
    chk(!busy && frame_n && irdy_n, "R1 no second transaction", int'(busy), 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule